// File: doc/BRIEF.md
# UART Byte Forwarding Bridge

This block couples an incoming asynchronous serial line to an outgoing one so that each character received is re-sent with no more than one character of storage in between. The receive side assembles a frame in its own shift register. When the frame is complete, the byte is reported on a one-cycle valid strobe and, if forwarding is on, copied into a single transmit holding register. The transmit side takes the byte from the holding register into its output shift register as soon as it is idle and sends it with no further control. While that byte is on the wire, the receiver is already collecting the next one.

Both directions use 8N1 framing. A bit lasts a fixed number of pulses of a shared oversampling tick, 16 by default. The received-byte output is a plain valid strobe with data. It has no ready input and cannot apply back-pressure, so a consumer that needs the byte must capture it in the cycle the strobe is high. The only form of back-pressure inside the block is the transmit holding register. When a byte completes while that register is still occupied, the new byte is discarded and a sticky overrun flag is raised.

Top module: `uart_fwd_bridge`

## Requirements
- R1: A frame with a low start bit, 8 data bits sent least significant bit first, and a high stop bit produces a one-cycle `rx_valid` pulse, with the assembled byte on `rx_data` in that cycle.
- R2: A forwarded byte leaves on `tx_line` as one low start bit, the 8 data bits least significant first and one high stop bit. Each bit lasts OVERSAMPLE ticks. The line rests high when no frame is being sent.
- R3: Bytes that arrive back to back at the nominal bit rate are all forwarded, in the order received, with none lost.
- R4: End-to-end delay is one byte. The forwarded start bit begins between 9 and 11 bit times after the received start bit, so transmission of a byte overlaps reception of the next.
- R5: A falling edge on `rx_line` that is no longer low at the middle of the start bit (tick OVERSAMPLE/2) is treated as noise. It gives no pulse and nothing is transmitted.
- R6: While `fwd_en` is low, received bytes still pulse `rx_valid`, but nothing is transmitted.
- R7: A byte that completes while the transmit holding register is occupied is dropped and sets `overrun`. The flag stays set until reset. Bytes accepted earlier are still sent, in order.
- R8: After reset, `tx_line` is high, `rx_valid` is low and `overrun` is low.
- R9: A frame whose stop bit samples low is discarded. It gives no pulse and nothing is transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle oversampling tick, OVERSAMPLE per bit, shared by both directions |
| fwd_en | input | 1 | High to forward received bytes to the transmitter |
| rx_line | input | 1 | Serial receive line, idle high |
| tx_line | output | 1 | Serial transmit line, idle high |
| rx_valid | output | 1 | One-cycle strobe for a received byte; no ready, no back-pressure |
| rx_data | output | DATA_BITS | Received byte, valid while rx_valid is high |
| overrun | output | 1 | Sticky flag: a byte was dropped because the holding register was occupied |

## Verification
`rx_line` passes through a two-flop synchronizer, and a start edge is only noticed on the next tick. The `rx_valid` pulse is therefore due about 152 ticks after the start edge, at mid-stop, plus up to one tick and two clocks. The forwarded start bit falls one clock after that pulse, and each later transmitted bit lasts exactly 64 clocks with the bench's tick divider.

The bench decodes `tx_line` by itself. It waits half a bit after each falling edge and then samples every 64 clocks on the falling clock edge. This tolerates the start bit being up to one tick short because the tick phase varies. The latency check allows a window around the expected 9.5 bit times rather than a single cycle. All absence checks wait at least two full frames before counting outputs.

// File: rtl/uart_fwd_pkg.sv
package uart_fwd_pkg;

  typedef enum logic [1:0] {
    RXS_IDLE,
    RXS_START,
    RXS_DATA,
    RXS_STOP
  } rx_state_t;

endpackage

// File: rtl/uart_fwd_rx.sv
module uart_fwd_rx
  import uart_fwd_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line_in,
  output logic                 done,
  output logic [DATA_BITS-1:0] byte_out
);

  localparam int CW = $clog2(OVERSAMPLE);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_BITS - 1);

  logic                 sync_a, sync_b;
  rx_state_t            state;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bitn;
  logic [DATA_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b1;
      sync_b <= 1'b1;
    end else begin
      sync_a <= line_in;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RXS_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      done     <= 1'b0;
      byte_out <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          RXS_IDLE: begin
            if (!sync_b) begin
              state <= RXS_START;
              cnt   <= '0;
            end
          end
          RXS_START: begin
            if (cnt == CNT_MID) begin
              cnt  <= '0;
              bitn <= '0;
              state <= sync_b ? RXS_IDLE : RXS_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RXS_DATA: begin
            if (cnt == CNT_LAST) begin
              cnt   <= '0;
              shreg <= {sync_b, shreg[DATA_BITS-1:1]};
              if (bitn == BIT_LAST) state <= RXS_STOP;
              else                  bitn  <= bitn + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RXS_STOP: begin
            if (cnt == CNT_LAST) begin
              cnt   <= '0;
              state <= RXS_IDLE;
              if (sync_b) begin
                done     <= 1'b1;
                byte_out <= shreg;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RXS_IDLE;
        endcase
      end
    end
  end

  // R1: the completion strobe lasts a single cycle
  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: a start seen high at mid-bit returns to idle rather than collecting data
  assert_glitch_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RXS_START && tick && cnt == CNT_MID && sync_b) |=> state == RXS_IDLE);

endmodule

// File: rtl/uart_fwd_hold.sv
module uart_fwd_hold #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fwd_en,
  input  logic                 in_valid,
  input  logic [DATA_BITS-1:0] in_byte,
  input  logic                 take,
  output logic                 full,
  output logic [DATA_BITS-1:0] data,
  output logic                 overrun
);

  logic accept;
  assign accept = in_valid && fwd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      data    <= '0;
      overrun <= 1'b0;
    end else begin
      if (accept && full && !take) begin
        overrun <= 1'b1;
      end else if (accept) begin
        data <= in_byte;
        full <= 1'b1;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  // R7: the overrun flag never clears outside reset
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R7: a dropped byte leaves the held byte untouched
  assert_drop_keeps_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && full && !take) |=> $stable(data) && full);

  // R4: an accepted byte lands in the holding register on the next cycle
  assert_cut_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !full) |=> full);

  // R6: with forwarding off nothing enters an empty holding register
  assert_disabled_no_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwd_en && !full) |=> !full);

endmodule

// File: rtl/uart_fwd_tx.sv
module uart_fwd_tx #(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 hold_full,
  input  logic [DATA_BITS-1:0] hold_data,
  output logic                 take,
  output logic                 line_out
);

  localparam int FRAME = DATA_BITS + 2;
  localparam int CW    = $clog2(OVERSAMPLE);
  localparam int FW    = $clog2(FRAME);
  localparam logic [CW-1:0] CNT_LAST   = CW'(OVERSAMPLE - 1);
  localparam logic [FW-1:0] FRAME_LAST = FW'(FRAME - 1);

  logic             busy;
  logic [FRAME-1:0] shreg;
  logic [CW-1:0]    cnt;
  logic [FW-1:0]    bitn;

  assign take     = hold_full && !busy;
  assign line_out = !busy || shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      cnt   <= '0;
      bitn  <= '0;
    end else if (take) begin
      busy  <= 1'b1;
      shreg <= {1'b1, hold_data, 1'b0};
      cnt   <= '0;
      bitn  <= '0;
    end else if (busy && tick) begin
      if (cnt == CNT_LAST) begin
        cnt   <= '0;
        shreg <= {1'b1, shreg[FRAME-1:1]};
        if (bitn == FRAME_LAST) busy <= 1'b0;
        else                    bitn <= bitn + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: a frame always opens with a low start bit
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !line_out);

  // R2: the line only moves while a frame is in progress
  assert_idle_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take) |=> line_out);

endmodule

// File: rtl/uart_fwd_bridge.sv
module uart_fwd_bridge #(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 fwd_en,
  input  logic                 rx_line,
  output logic                 tx_line,
  output logic                 rx_valid,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 overrun
);

  logic                 hold_full;
  logic [DATA_BITS-1:0] hold_data;
  logic                 tx_take;

  uart_fwd_rx #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .line_in  (rx_line),
    .done     (rx_valid),
    .byte_out (rx_data)
  );

  uart_fwd_hold #(.DATA_BITS(DATA_BITS)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .fwd_en   (fwd_en),
    .in_valid (rx_valid),
    .in_byte  (rx_data),
    .take     (tx_take),
    .full     (hold_full),
    .data     (hold_data),
    .overrun  (overrun)
  );

  uart_fwd_tx #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .take      (tx_take),
    .line_out  (tx_line)
  );

  // R8: reset leaves the outputs quiet
  assert_reset_quiet_R8: assert property (@(posedge clk)
    $rose(rst_n) |-> tx_line && !rx_valid && !overrun);

endmodule

// File: tb/uart_fwd_bridge_bench.sv
module uart_fwd_bridge_bench;

  localparam int BITCLK = 64;  // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       fwd_en = 1'b1;
  logic       rx_line = 1'b1;
  logic       tx_line;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       overrun;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [1:0] div = '0;

  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  int         rx_t[$];
  int         tx_t[$];
  int         tx_badstop = 0;

  uart_fwd_bridge u_uart_fwd_bridge (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .fwd_en(fwd_en),
    .rx_line(rx_line), .tx_line(tx_line), .rx_valid(rx_valid),
    .rx_data(rx_data), .overrun(overrun)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    div       <= div + 2'd1;
    baud_tick <= (div == 2'd3);
  end

  always @(negedge clk) if (rst_n && rx_valid) rxq.push_back(rx_data);

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx_line === 1'b0) begin
        logic [7:0] b;
        int t0;
        t0 = cyc;
        repeat (BITCLK / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (BITCLK) @(negedge clk);
          b[i] = tx_line;
        end
        repeat (BITCLK) @(negedge clk);
        if (tx_line !== 1'b1) tx_badstop++;
        txq.push_back(b);
        tx_t.push_back(t0);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_q();
    rxq.delete(); txq.delete(); rx_t.delete(); tx_t.delete();
  endtask

  task automatic send(input logic [7:0] b, input int stop_ticks, input logic stop_v);
    @(negedge clk);
    rx_t.push_back(cyc);
    rx_line = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      repeat (BITCLK) @(negedge clk);
    end
    rx_line = stop_v;
    repeat (stop_ticks * 4) @(negedge clk);
    rx_line = 1'b1;
  endtask

  task automatic settle();
    repeat (BITCLK * 22) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_line === 1'b1, "R8", "tx_line after reset", tx_line, 1);
    chk(rx_valid === 1'b0, "R8", "rx_valid after reset", rx_valid, 0);
    chk(overrun === 1'b0, "R8", "overrun after reset", overrun, 0);
  endtask

  task automatic t_single();
    clear_q();
    send(8'hA5, 16, 1'b1);
    settle();
    chk(rxq.size() == 1, "R1", "pulse count", rxq.size(), 1);
    if (rxq.size() == 1) chk(rxq[0] == 8'hA5, "R1", "rx_data", rxq[0], 8'hA5);
    chk(txq.size() == 1, "R2", "frames sent", txq.size(), 1);
    if (txq.size() == 1) begin
      chk(txq[0] == 8'hA5, "R2", "sent byte", txq[0], 8'hA5);
      chk(tx_t[0] - rx_t[0] >= 9 * BITCLK && tx_t[0] - rx_t[0] <= 11 * BITCLK,
          "R4", "start-to-start clocks", tx_t[0] - rx_t[0], 608);
    end
    chk(tx_badstop == 0, "R2", "bad stop bits on tx", tx_badstop, 0);
  endtask

  task automatic t_burst();
    logic [7:0] pat[4] = '{8'h00, 8'hFF, 8'h3C, 8'h81};
    clear_q();
    for (int i = 0; i < 4; i++) send(pat[i], 16, 1'b1);
    settle();
    chk(txq.size() == 4, "R3", "burst frames sent", txq.size(), 4);
    for (int i = 0; i < 4 && i < txq.size(); i++) begin
      chk(txq[i] == pat[i], "R3", "burst byte order", txq[i], pat[i]);
      chk(tx_t[i] - rx_t[i] <= 11 * BITCLK && tx_t[i] - rx_t[i] >= 9 * BITCLK,
          "R4", "burst latency clocks", tx_t[i] - rx_t[i], 608);
    end
    chk(overrun === 1'b0, "R3", "no overrun at nominal rate", overrun, 0);
  endtask

  task automatic t_glitch();
    clear_q();
    @(negedge clk);
    rx_line = 1'b0;
    repeat (12) @(negedge clk);
    rx_line = 1'b1;
    settle();
    chk(rxq.size() == 0, "R5", "pulses after glitch", rxq.size(), 0);
    chk(txq.size() == 0, "R5", "frames after glitch", txq.size(), 0);
  endtask

  task automatic t_bad_stop();
    clear_q();
    send(8'h5A, 16, 1'b0);
    settle();
    chk(rxq.size() == 0, "R9", "pulses after bad stop", rxq.size(), 0);
    chk(txq.size() == 0, "R9", "frames after bad stop", txq.size(), 0);
  endtask

  task automatic t_disabled();
    clear_q();
    fwd_en = 1'b0;
    send(8'hC3, 16, 1'b1);
    settle();
    chk(rxq.size() == 1, "R6", "pulses while disabled", rxq.size(), 1);
    if (rxq.size() == 1) chk(rxq[0] == 8'hC3, "R6", "rx_data while disabled", rxq[0], 8'hC3);
    chk(txq.size() == 0, "R6", "frames while disabled", txq.size(), 0);
    fwd_en = 1'b1;
  endtask

  task automatic t_overrun();
    int k = 0;
    bit ordered = 1'b1;
    clear_q();
    // 12-tick stop bits: bytes arrive a little faster than they can leave
    for (int i = 0; i < 48; i++) send(8'(i * 5 + 1), 12, 1'b1);
    settle();
    chk(rxq.size() == 48, "R7", "pulses during overrun run", rxq.size(), 48);
    chk(overrun === 1'b1, "R7", "overrun set", overrun, 1);
    chk(txq.size() < 48 && txq.size() > 30, "R7", "frames sent with drops", txq.size(), 47);
    for (int i = 0; i < txq.size(); i++) begin
      while (k < 48 && 8'(k * 5 + 1) != txq[i]) k++;
      if (k >= 48) ordered = 1'b0;
      k++;
    end
    chk(ordered, "R7", "sent bytes are an ordered subset", ordered, 1);
    repeat (BITCLK * 20) @(negedge clk);
    chk(overrun === 1'b1, "R7", "overrun still set later", overrun, 1);
  endtask

  task automatic t_reset_again();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(overrun === 1'b0, "R8", "overrun cleared by reset", overrun, 0);
    chk(tx_line === 1'b1, "R8", "tx_line high after reset", tx_line, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_burst();
    t_glitch();
    t_bad_stop();
    t_disabled();
    t_overrun();
    t_reset_again();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule